// File: doc/BRIEF.md
# Time-Shared Radix-4 Viterbi Path-Metric Array

This block updates the path metrics of a 128-state Viterbi trellis in which every state has four incoming branches, one for each quaternary symbol. The trellis is a shift-register trellis. State `n` is reached from the four predecessors `{k, n[6:2]}` for `k = 0..3`, and the symbol on that transition is `n[1:0]`. The states therefore fall into 32 groups of four. Each group reads the same four predecessor metrics, so all metric routing stays inside the group.

Each group is handled by one radix-4 unit made of two add-compare-select elements. The add and first-level compare sit in one pipeline stage, and the final compare sits in a second stage. Because of the metric feedback, a new symbol cannot enter until the previous one is written back. That leaves a free slot in each element, and it is filled with a second output state. Each element produces two new metrics per symbol, so half the usual number of elements is needed. A new symbol is accepted every third clock cycle.

The block outputs every updated metric and a 2-bit survivor decision per state. Survivor storage and traceback belong to a separate block.

Top module: `vit_acs_array`

## Requirements
- R1: After reset, and after a start, state 0 holds metric 0, every other state holds `INIT_VAL` (512), all decisions are 0, `ready_o` is 1 and `out_valid_o` is 0.
- R2: The candidates for state `n` are `sm[k*32 + n[6:2]] + bm(k, n[1:0])` for `k = 0..3`. The 6-bit branch metric `bm(k, s)` sits in `bm_i[(4*k+s)*6 +: 6]`, and it is sampled only in the accepting cycle.
- R3: The new metric of each state is the smallest of its four candidates, reduced modulo 4096 and placed in `sm_o[n*12 +: 12]`.
- R4: `dec_o[2*n +: 2]` holds the `k` of the winning candidate. When candidates tie, the lowest `k` wins.
- R5: Metrics compare by the sign bit of their 12-bit difference. Updates stay correct after metrics wrap past 4095, as long as all live metrics lie within 2047 of each other.
- R6: If `sym_valid_i` and `ready_o` are both high in cycle `a` (with no start), `out_valid_o` is high for exactly one cycle, in cycle `a+4`. At that point all of `sm_o` and `dec_o` show the new symbol.
- R7: `ready_o` is low in cycles `a+1` and `a+2` and high again in `a+3`. A `sym_valid_i` or `bm_i` change while `ready_o` is low is ignored.
- R8: `start_i` takes priority over everything. It aborts any symbol in flight, so no `out_valid_o` follows it, and it refuses a symbol offered in the same cycle. The metrics then return to the values of R1.
- R9: While no symbol is in flight, `sm_o` and `dec_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Reinitialise metrics, abort work in flight |
| sym_valid_i | input | 1 | Branch metrics for a new symbol are present |
| bm_i | input | 96 | 16 branch metrics of 6 bits, slot `4*k+s` |
| ready_o | output | 1 | A new symbol can be taken this cycle |
| out_valid_o | output | 1 | One-cycle pulse: metrics and decisions updated |
| sm_o | output | 1536 | 128 path metrics of 12 bits, state `n` at `n*12` |
| dec_o | output | 256 | 128 survivor decisions of 2 bits, state `n` at `2*n` |

## Verification
The bench goes after four corner cases.

- **Ties.** All-zero branch metrics after a start force four-way ties. A design that broke ties toward the higher index, or let the second compare level override an equal first-level winner, would report nonzero decisions.
- **Wrap-around.** A long run of large branch metrics drives every metric past 4095. An unsigned comparator would then pick the wrapped path and corrupt both metrics and decisions.
- **Time-sharing.** Junk metrics and a held-high valid during the busy cycles expose a design that samples `bm_i` late. The same test exposes a design that lets the second phase see metrics already overwritten by the first phase.
- **Start.** A start issued mid-flight, or together with a symbol, must leave no stray output pulse and must leave the initial metrics.

// File: rtl/vit_acs_pkg.sv
package vit_acs_pkg;

  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } phase_e;

  // slot of branch metric for predecessor high bits k and symbol s
  function automatic int unsigned bm_slot(input int unsigned k, input int unsigned s);
    return k * 4 + s;
  endfunction

endpackage

// File: rtl/vit_acs_elem.sv
module vit_acs_elem #(
  parameter int SM_W = 12,
  parameter int BM_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [SM_W-1:0] pred_sm_i [4],
  input  logic [BM_W-1:0] bm_i      [4],
  output logic [SM_W-1:0] sm_o,
  output logic [1:0]      dec_o
);

  // modulo compare: a < b when the wrapped difference is negative
  function automatic logic mod_lt(input logic [SM_W-1:0] a, input logic [SM_W-1:0] b);
    logic [SM_W-1:0] d;
    d = a - b;
    return d[SM_W-1];
  endfunction

  logic [SM_W-1:0] cand [4];
  logic            sel_lo, sel_hi;
  logic [SM_W-1:0] win_lo, win_hi;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      cand[k] = pred_sm_i[k] + {{(SM_W-BM_W){1'b0}}, bm_i[k]};
    end
    sel_lo = mod_lt(cand[1], cand[0]);
    sel_hi = mod_lt(cand[3], cand[2]);
    win_lo = sel_lo ? cand[1] : cand[0];
    win_hi = sel_hi ? cand[3] : cand[2];
  end

  logic [SM_W-1:0] win_lo_q, win_hi_q;
  logic            sel_lo_q, sel_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_lo_q <= '0;
      win_hi_q <= '0;
      sel_lo_q <= 1'b0;
      sel_hi_q <= 1'b0;
    end else if (en_i) begin
      win_lo_q <= win_lo;
      win_hi_q <= win_hi;
      sel_lo_q <= sel_lo;
      sel_hi_q <= sel_hi;
    end
  end

  // second level: the upper pair wins only when strictly smaller
  logic pick_hi;
  always_comb begin
    pick_hi = mod_lt(win_hi_q, win_lo_q);
    sm_o    = pick_hi ? win_hi_q : win_lo_q;
    dec_o   = {pick_hi, pick_hi ? sel_hi_q : sel_lo_q};
  end

endmodule

// File: rtl/vit_r4_unit.sv
module vit_r4_unit
  import vit_acs_pkg::*;
#(
  parameter int SM_W = 12,
  parameter int BM_W = 6,
  parameter int NBM  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  phase_e            phase_i,
  input  logic [SM_W-1:0]   pred_sm_i [4],
  input  logic [NBM*BM_W-1:0] bm_i,
  output logic [SM_W-1:0]   sm_o  [2],
  output logic [1:0]        dec_o [2]
);

  for (genvar e = 0; e < 2; e++) begin : g_elem
    logic [BM_W-1:0] bm_sel [4];
    int unsigned     sym;

    always_comb begin
      sym = 2 * e + ((phase_i == PH_HI) ? 1 : 0);
      for (int k = 0; k < 4; k++) begin
        bm_sel[k] = bm_i[bm_slot(k, sym)*BM_W +: BM_W];
      end
    end

    vit_acs_elem #(
      .SM_W(SM_W),
      .BM_W(BM_W)
    ) acs_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .pred_sm_i(pred_sm_i),
      .bm_i     (bm_sel),
      .sm_o     (sm_o[e]),
      .dec_o    (dec_o[e])
    );
  end

endmodule

// File: rtl/vit_acs_ctrl.sv
module vit_acs_ctrl
  import vit_acs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   sym_valid_i,
  output logic   ready_o,
  output logic   accept_o,
  output logic   a_en_o,
  output phase_e a_ph_o,
  output logic   b_we_o,
  output phase_e b_ph_o,
  output logic   done_o
);

  logic ph0_q, ph1_q, bv_q, bph_q, done_q;

  assign ready_o  = ~ph0_q & ~ph1_q;
  assign accept_o = sym_valid_i & ready_o & ~start_i;
  assign a_en_o   = ph0_q | ph1_q;
  assign a_ph_o   = ph1_q ? PH_HI : PH_LO;
  assign b_we_o   = bv_q;
  assign b_ph_o   = bph_q ? PH_HI : PH_LO;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph0_q  <= 1'b0;
      ph1_q  <= 1'b0;
      bv_q   <= 1'b0;
      bph_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      ph0_q  <= 1'b0;
      ph1_q  <= 1'b0;
      bv_q   <= 1'b0;
      bph_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph0_q  <= accept_o;
      ph1_q  <= ph0_q;
      bv_q   <= ph0_q | ph1_q;
      bph_q  <= ph1_q;
      done_q <= bv_q & bph_q;
    end
  end

endmodule

// File: rtl/vit_acs_array.sv
module vit_acs_array
  import vit_acs_pkg::*;
#(
  parameter int N_STATES = 128,
  parameter int SM_W     = 12,
  parameter int BM_W     = 6,
  parameter int INIT_VAL = 512
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     sym_valid_i,
  input  logic [16*BM_W-1:0]       bm_i,
  output logic                     ready_o,
  output logic                     out_valid_o,
  output logic [N_STATES*SM_W-1:0] sm_o,
  output logic [2*N_STATES-1:0]    dec_o
);

  localparam int NBM    = 16;
  localparam int GROUPS = N_STATES / 4;
  localparam int N_ELEM = GROUPS * 2;
  localparam logic [SM_W-1:0] INIT_SM = INIT_VAL[SM_W-1:0];

  logic   accept, a_en, b_we;
  phase_e a_ph, b_ph;

  vit_acs_ctrl ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sym_valid_i(sym_valid_i),
    .ready_o    (ready_o),
    .accept_o   (accept),
    .a_en_o     (a_en),
    .a_ph_o     (a_ph),
    .b_we_o     (b_we),
    .b_ph_o     (b_ph),
    .done_o     (out_valid_o)
  );

  logic [NBM*BM_W-1:0] bm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bm_q <= '0;
    else if (accept) bm_q <= bm_i;
  end

  logic [SM_W-1:0] sm_q  [N_STATES];
  logic [1:0]      dec_q [N_STATES];
  logic [SM_W-1:0] wr_sm  [N_ELEM];
  logic [1:0]      wr_dec [N_ELEM];

  for (genvar g = 0; g < GROUPS; g++) begin : g_unit
    logic [SM_W-1:0] pred [4];
    logic [SM_W-1:0] u_sm  [2];
    logic [1:0]      u_dec [2];

    always_comb begin
      for (int k = 0; k < 4; k++) pred[k] = sm_q[k*GROUPS + g];
    end

    vit_r4_unit #(
      .SM_W(SM_W),
      .BM_W(BM_W),
      .NBM (NBM)
    ) unit_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (a_en),
      .phase_i  (a_ph),
      .pred_sm_i(pred),
      .bm_i     (bm_q),
      .sm_o     (u_sm),
      .dec_o    (u_dec)
    );

    for (genvar e = 0; e < 2; e++) begin : g_wr
      assign wr_sm[g*2+e]  = u_sm[e];
      assign wr_dec[g*2+e] = u_dec[e];
    end
  end

  // element i of the current phase writes state {i, phase}
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < N_STATES; n++) begin
        sm_q[n]  <= (n == 0) ? '0 : INIT_SM;
        dec_q[n] <= '0;
      end
    end else if (start_i) begin
      for (int n = 0; n < N_STATES; n++) begin
        sm_q[n]  <= (n == 0) ? '0 : INIT_SM;
        dec_q[n] <= '0;
      end
    end else if (b_we) begin
      for (int i = 0; i < N_ELEM; i++) begin
        sm_q[i*2 + ((b_ph == PH_HI) ? 1 : 0)]  <= wr_sm[i];
        dec_q[i*2 + ((b_ph == PH_HI) ? 1 : 0)] <= wr_dec[i];
      end
    end
  end

  always_comb begin
    for (int n = 0; n < N_STATES; n++) begin
      sm_o[n*SM_W +: SM_W] = sm_q[n];
      dec_o[2*n +: 2]      = dec_q[n];
    end
  end

endmodule

// File: rtl/vit_acs_array_chk.sv
module vit_acs_array_chk #(
  parameter int N_STATES = 128,
  parameter int SM_W     = 12,
  parameter int INIT_VAL = 512
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     sym_valid_i,
  input logic                     ready_o,
  input logic                     out_valid_o,
  input logic [N_STATES*SM_W-1:0] sm_o,
  input logic [2*N_STATES-1:0]    dec_o
);

  logic acc, acc_d1;
  assign acc = sym_valid_i & ready_o & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_d1 <= 1'b0;
    else         acc_d1 <= acc;
  end

  // R7
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !ready_o);

  // R7
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_d1 && !start_i |=> !ready_o);

  // R6
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  // R6
  pulse_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(ready_o) && !$past(ready_o, 2));

  // R8
  start_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> sm_o[SM_W-1:0] == '0 && sm_o[2*SM_W-1:SM_W] == INIT_VAL[SM_W-1:0]
                && ready_o && !out_valid_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && $past(ready_o) && !sym_valid_i && !start_i |=> $stable(sm_o) && $stable(dec_o));

endmodule

bind vit_acs_array vit_acs_array_chk #(
  .N_STATES(N_STATES),
  .SM_W    (SM_W),
  .INIT_VAL(INIT_VAL)
) chk_i (.*);

// File: tb/vit_acs_array_tb_top.sv
`timescale 1ns/1ps
module vit_acs_array_tb_top;

  localparam int NS   = 128;
  localparam int SMW  = 12;
  localparam int BMW  = 6;
  localparam int GRP  = NS / 4;
  localparam int INIT = 512;

  logic               clk, rst_n, start, valid;
  logic [16*BMW-1:0]  bm_in;
  logic               ready, ovalid;
  logic [NS*SMW-1:0]  sm_out;
  logic [2*NS-1:0]    dec_out;

  int checks = 0;
  int errors = 0;
  int ref_sm [NS];

  logic [NS*SMW-1:0] q_sm  [$];
  logic [2*NS-1:0]   q_dec [$];

  vit_acs_array dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .sym_valid_i(valid),
    .bm_i       (bm_in),
    .ready_o    (ready),
    .out_valid_o(ovalid),
    .sm_o       (sm_out),
    .dec_o      (dec_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [NS*SMW-1:0] init_vec();
    logic [NS*SMW-1:0] v;
    for (int n = 0; n < NS; n++) v[n*SMW +: SMW] = (n == 0) ? '0 : SMW'(INIT);
    return v;
  endfunction

  function automatic logic [NS*SMW-1:0] ref_vec();
    logic [NS*SMW-1:0] v;
    for (int n = 0; n < NS; n++) v[n*SMW +: SMW] = SMW'(ref_sm[n] % 4096);
    return v;
  endfunction

  task automatic ref_init();
    for (int n = 0; n < NS; n++) ref_sm[n] = (n == 0) ? 0 : INIT;
  endtask

  // R2 R3 R4: true-valued reference update, lowest k on ties
  task automatic ref_step(input logic [16*BMW-1:0] bm, output logic [2*NS-1:0] edec);
    int nxt [NS];
    for (int n = 0; n < NS; n++) begin
      int best, bk, s, g;
      s = n % 4;
      g = n / 4;
      best = ref_sm[g] + int'(bm[s*BMW +: BMW]);
      bk = 0;
      for (int k = 1; k < 4; k++) begin
        int c;
        c = ref_sm[k*GRP + g] + int'(bm[(4*k+s)*BMW +: BMW]);
        if (c < best) begin
          best = c;
          bk = k;
        end
      end
      nxt[n] = best;
      edec[2*n +: 2] = 2'(bk);
    end
    for (int n = 0; n < NS; n++) ref_sm[n] = nxt[n];
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: offer one symbol, push expectation when tracked
  task automatic send(input logic [16*BMW-1:0] bm, input bit track);
    logic [2*NS-1:0] ed;
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1;
    bm_in = bm;
    if (track) begin
      ref_step(bm, ed);
      q_sm.push_back(ref_vec());
      q_dec.push_back(ed);
    end
    @(negedge clk);
    valid = 1'b0;
    bm_in = '0;
  endtask

  function automatic logic [16*BMW-1:0] rand_bm(input int lo, input int hi);
    logic [16*BMW-1:0] v;
    for (int i = 0; i < 16; i++) v[i*BMW +: BMW] = BMW'($urandom_range(hi, lo));
    return v;
  endfunction

  task automatic do_start(input logic with_valid);
    @(negedge clk);
    start = 1'b1;
    valid = with_valid;
    bm_in = rand_bm(0, 63);
    @(negedge clk);
    start = 1'b0;
    valid = 1'b0;
    ref_init();
    chk(sm_out == init_vec(), "R8", "metrics after start", int'(sm_out[SMW +: SMW]), INIT);
    chk(dec_out == '0, "R1", "decisions after start", int'(dec_out[1:0]), 0);
    chk(ready == 1'b1, "R8", "ready after start", int'(ready), 1);
  endtask

  // monitor: pop and compare on every output pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ovalid) begin
        if (q_sm.size() == 0) begin
          chk(1'b0, "R6", "unexpected out_valid", 1, 0);
        end else begin
          logic [NS*SMW-1:0] es;
          logic [2*NS-1:0]   ed;
          int bad;
          es = q_sm.pop_front();
          ed = q_dec.pop_front();
          bad = -1;
          for (int n = NS - 1; n >= 0; n--) if (sm_out[n*SMW +: SMW] != es[n*SMW +: SMW]) bad = n;
          chk(bad < 0, "R2/R3", $sformatf("metric state %0d", bad < 0 ? 0 : bad),
              bad < 0 ? 0 : int'(sm_out[bad*SMW +: SMW]), bad < 0 ? 0 : int'(es[bad*SMW +: SMW]));
          bad = -1;
          for (int n = NS - 1; n >= 0; n--) if (dec_out[2*n +: 2] != ed[2*n +: 2]) bad = n;
          chk(bad < 0, "R4", $sformatf("decision state %0d", bad < 0 ? 0 : bad),
              bad < 0 ? 0 : int'(dec_out[2*bad +: 2]), bad < 0 ? 0 : int'(ed[2*bad +: 2]));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NS*SMW-1:0] snap_sm;
    logic [2*NS-1:0]   snap_dec;
    int mn;
    start = 1'b0;
    valid = 1'b0;
    bm_in = '0;
    rst_n = 1'b0;
    ref_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sm_out == init_vec(), "R1", "reset metrics", int'(sm_out[SMW +: SMW]), INIT);
    chk(dec_out == '0, "R1", "reset decisions", int'(dec_out[1:0]), 0);
    chk(ready == 1'b1, "R1", "reset ready", int'(ready), 1);
    chk(ovalid == 1'b0, "R1", "reset out_valid", int'(ovalid), 0);

    // R4 all-zero metrics: every state ties toward k=0
    send('0, 1'b1);
    repeat (5) @(negedge clk);
    chk(dec_out == '0, "R4", "tie decisions all zero", int'(dec_out[7:0]), 0);

    // R6 R7 timing, with junk while busy
    begin
      logic [2*NS-1:0] ed;
      @(negedge clk);
      while (!ready) @(negedge clk);
      valid = 1'b1;
      bm_in = rand_bm(0, 63);
      ref_step(bm_in, ed);
      q_sm.push_back(ref_vec());
      q_dec.push_back(ed);
      @(negedge clk);
      chk(!ready, "R7", "ready low a+1", int'(ready), 0);
      bm_in = rand_bm(0, 63);
      @(negedge clk);
      chk(!ready, "R7", "ready low a+2", int'(ready), 0);
      bm_in = rand_bm(0, 63);
      @(negedge clk);
      chk(ready, "R7", "ready high a+3", int'(ready), 1);
      chk(!ovalid, "R6", "no pulse a+3", int'(ovalid), 0);
      valid = 1'b0;
      bm_in = '0;
      @(negedge clk);
      chk(ovalid, "R6", "pulse a+4", int'(ovalid), 1);
    end

    // R2 R3 R4 random symbols
    for (int i = 0; i < 150; i++) send(rand_bm(0, 63), 1'b1);

    // R5 large metrics force wrap past 4095
    for (int i = 0; i < 120; i++) send(rand_bm(40, 63), 1'b1);
    repeat (6) @(negedge clk);
    mn = ref_sm[0];
    for (int n = 1; n < NS; n++) if (ref_sm[n] < mn) mn = ref_sm[n];
    chk(mn > 4096, "R5", "metrics wrapped", mn, 4097);

    // R9 hold while idle
    snap_sm = sm_out;
    snap_dec = dec_out;
    repeat (10) @(negedge clk);
    chk(sm_out == snap_sm, "R9", "metrics held", int'(sm_out[SMW-1:0]), int'(snap_sm[SMW-1:0]));
    chk(dec_out == snap_dec, "R9", "decisions held", int'(dec_out[1:0]), int'(snap_dec[1:0]));

    // R8 start when idle, start with symbol offered
    do_start(1'b0);
    for (int i = 0; i < 10; i++) send(rand_bm(0, 63), 1'b1);
    repeat (6) @(negedge clk);
    do_start(1'b1);
    repeat (6) @(negedge clk);
    chk(sm_out == init_vec(), "R8", "symbol with start refused", int'(sm_out[SMW-1:0]), 0);

    // R8 abort in flight
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1;
    bm_in = rand_bm(0, 63);
    @(negedge clk);
    valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ref_init();
    repeat (6) @(negedge clk);
    chk(sm_out == init_vec(), "R8", "abort leaves init", int'(sm_out[SMW +: SMW]), INIT);

    for (int i = 0; i < 40; i++) send(rand_bm(0, 63), 1'b1);
    repeat (8) @(negedge clk);
    chk(q_sm.size() == 0, "R6", "all outputs seen", q_sm.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule